// File: doc/BRIEF.md
# LIN response length byte counter

This block holds the two 4-bit data-length fields used for the response part of a LIN frame. While idle, software loads a receive length and a transmit length. A start strobe then opens a response in the chosen direction. At that moment the length of the active direction is limited to 8, and the field of the opposite direction is cleared.

For the rest of the transfer, the opposite field serves as a live count of bytes that have completed without error. When the count reaches the clamped length, the block raises a flag that marks the next byte as the checksum. When that checksum byte completes, the block emits a one-cycle completion pulse.

An error strobe ends the response early and leaves the count in place, so software can see how far the transfer got before the error.

Top module: `lin_resp_len`

## Requirements
- R1: After reset, both fields read 0, and busy_o, chk_next_o and done_o are 0.
- R2: While idle, a cycle with wr_en_i high and start_i low loads rx_len_o and tx_len_o with the written values unchanged (0 to 15) on the next cycle.
- R3: On start_i while idle, busy_o rises on the next cycle. start_tx_i=1 selects transmit and 0 selects receive. The length field of the selected direction becomes its value limited to 8, and the other field becomes 0.
- R4: A transmit start with a transmit length of 0 raises chk_next_o in the first busy cycle, so only the checksum is sent.
- R5: A receive start with a receive length of 0 raises chk_next_o in the first busy cycle, so the first received byte is the checksum.
- R6: While busy, a byte_done_i without err_i, when chk_next_o is low, adds one to the counting field. During transmit the counting field is rx_len_o, and during receive it is tx_len_o. The length field does not change.
- R7: chk_next_o is high exactly when busy_o is high and the counting field equals the length field.
- R8: A byte_done_i without err_i while chk_next_o is high gives a one-cycle done_o pulse on the next cycle and clears busy_o. Both fields hold their values.
- R9: err_i while busy clears busy_o on the next cycle with no done_o pulse. Both fields hold, and this also holds when byte_done_i arrives in the same cycle.
- R10: Writes are ignored while busy and in the cycle of an accepted start. A start_i while busy is ignored.
- R11: byte_done_i and err_i while idle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write of both length fields |
| wr_rx_len_i | input | 4 | Receive length to write |
| wr_tx_len_i | input | 4 | Transmit length to write |
| start_i | input | 1 | Response start strobe |
| start_tx_i | input | 1 | Direction with start: 1 transmit, 0 receive |
| byte_done_i | input | 1 | A response byte completed |
| err_i | input | 1 | Response error, aborts the transfer |
| rx_len_o | output | 4 | Receive length, or sent-byte count during transmit |
| tx_len_o | output | 4 | Transmit length, or received-byte count during receive |
| busy_o | output | 1 | Response in progress |
| chk_next_o | output | 1 | Next byte is the checksum |
| done_o | output | 1 | One-cycle pulse after the checksum byte |

## Verification
The hardest case to reach is an error that arrives in the same cycle as a byte completion, in the middle of a clamped transfer. To get there, the bench first writes a length above 8 and counts a few bytes. It then strobes both lines together and checks that the count freezes at the value from before that cycle. A long random phase, with start, byte and error strobes often overlapping, is compared against a behavioural model on every clock. This phase also covers writes and starts that collide with a busy response.

// File: rtl/lin_len_pkg.sv
package lin_len_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/lin_len_clamp.sv
module lin_len_clamp #(
  parameter int W   = 4,
  parameter int MAX = 8
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  assign val_o = (int'(val_i) > MAX) ? W'(MAX) : val_i;
endmodule

// File: rtl/lin_len_seq.sv
module lin_len_seq
  import lin_len_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_tx_i,
  input  logic byte_done_i,
  input  logic err_i,
  input  logic at_chk_i,
  output logic busy_o,
  output dir_e dir_o,
  output logic load_o,
  output logic cnt_en_o,
  output logic done_o
);
  logic busy_q, done_q, finish;
  dir_e dir_q;

  assign load_o   = start_i && !busy_q;
  assign finish   = busy_q && byte_done_i && !err_i && at_chk_i;
  assign cnt_en_o = busy_q && byte_done_i && !err_i && !at_chk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_RX;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (load_o) begin
        busy_q <= 1'b1;
        dir_q  <= start_tx_i ? DIR_TX : DIR_RX;
      end else if (busy_q && (err_i || finish)) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign dir_o  = dir_q;
  assign done_o = done_q;
endmodule

// File: rtl/lin_resp_len.sv
module lin_resp_len
  import lin_len_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LEN_W-1:0] wr_rx_len_i,
  input  logic [LEN_W-1:0] wr_tx_len_i,
  input  logic             start_i,
  input  logic             start_tx_i,
  input  logic             byte_done_i,
  input  logic             err_i,
  output logic [LEN_W-1:0] rx_len_o,
  output logic [LEN_W-1:0] tx_len_o,
  output logic             busy_o,
  output logic             chk_next_o,
  output logic             done_o
);
  localparam int NFLD = 2;  // 0: receive field, 1: transmit field

  logic [LEN_W-1:0] fld_q  [NFLD];
  logic [LEN_W-1:0] wr_val [NFLD];
  logic [LEN_W-1:0] clamped[NFLD];
  logic load, cnt_en, busy, at_chk;
  dir_e dir_q;

  assign wr_val[0] = wr_rx_len_i;
  assign wr_val[1] = wr_tx_len_i;

  // count == length is symmetric, so direction does not matter here
  assign at_chk = busy && (fld_q[0] == fld_q[1]);

  lin_len_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_tx_i (start_tx_i),
    .byte_done_i(byte_done_i),
    .err_i      (err_i),
    .at_chk_i   (at_chk),
    .busy_o     (busy),
    .dir_o      (dir_q),
    .load_o     (load),
    .cnt_en_o   (cnt_en),
    .done_o     (done_o)
  );

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    // field i counts when the active direction is the other one
    localparam dir_e OWN_DIR = (i == 1) ? DIR_TX : DIR_RX;
    logic own_start;

    assign own_start = (start_tx_i == (OWN_DIR == DIR_TX));

    lin_len_clamp #(.W(LEN_W), .MAX(MAX_LEN)) i_clamp (
      .val_i(fld_q[i]),
      .val_o(clamped[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fld_q[i] <= '0;
      end else if (load) begin
        fld_q[i] <= own_start ? clamped[i] : '0;
      end else if (cnt_en && dir_q != OWN_DIR) begin
        fld_q[i] <= fld_q[i] + 1'b1;
      end else if (wr_en_i && !busy && !start_i) begin
        fld_q[i] <= wr_val[i];
      end
    end
  end

  assign rx_len_o   = fld_q[0];
  assign tx_len_o   = fld_q[1];
  assign busy_o     = busy;
  assign chk_next_o = at_chk;
endmodule

// File: rtl/lin_resp_len_chk.sv
module lin_resp_len_chk
  import lin_len_pkg::*;
#(
  parameter int W   = 4,
  parameter int MAX = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         start_i,
  input logic         byte_done_i,
  input logic         err_i,
  input logic [W-1:0] rx_len_o,
  input logic [W-1:0] tx_len_o,
  input logic         busy_o,
  input logic         chk_next_o,
  input logic         done_o,
  input dir_e         dir_i
);
  a_r3_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && int'(rx_len_o) <= MAX && int'(tx_len_o) <= MAX));

  a_r6_tx_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dir_i == DIR_TX && !start_i) |=> $stable(tx_len_o));

  a_r6_rx_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && dir_i == DIR_RX && !start_i) |=> $stable(rx_len_o));

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_done_i && !err_i && !chk_next_o && dir_i == DIR_TX)
      |=> rx_len_o == $past(rx_len_o) + 1'b1);

  a_r8_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_done_i && !err_i && chk_next_o) |=> (done_o && !busy_o));

  a_r9_err_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_i) |=> (!busy_o && !done_o && $stable(rx_len_o) && $stable(tx_len_o)));

  a_r11_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && !wr_en_i) |=> ($stable(rx_len_o) && $stable(tx_len_o) && !busy_o));
endmodule

bind lin_resp_len lin_resp_len_chk #(.W(LEN_W), .MAX(MAX_LEN)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .start_i    (start_i),
  .byte_done_i(byte_done_i),
  .err_i      (err_i),
  .rx_len_o   (rx_len_o),
  .tx_len_o   (tx_len_o),
  .busy_o     (busy_o),
  .chk_next_o (chk_next_o),
  .done_o     (done_o),
  .dir_i      (dir_q)
);

// File: tb/test_lin_resp_len.sv
`timescale 1ns/1ps
module test_lin_resp_len;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, st = 0, stx = 0, bd = 0, er = 0;
  logic [3:0] wrx = 0, wtx = 0;
  logic [3:0] rx_o, tx_o;
  logic busy_o, chk_o, done_o;

  int n_tests = 0, n_fail = 0;
  int m_rx = 0, m_tx = 0;
  bit m_busy = 0, m_dir = 0, m_done = 0;
  bit run_cmp = 0;

  always #10 clk = ~clk;

  lin_resp_len i_lin_resp_len (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_rx_len_i(wrx), .wr_tx_len_i(wtx),
    .start_i(st), .start_tx_i(stx), .byte_done_i(bd), .err_i(er),
    .rx_len_o(rx_o), .tx_len_o(tx_o), .busy_o(busy_o), .chk_next_o(chk_o), .done_o(done_o)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx <= 0; m_tx <= 0; m_busy <= 0; m_dir <= 0; m_done <= 0;
    end else begin
      bit fin;
      fin = m_busy && bd && !er && (m_rx == m_tx);
      m_done <= fin;
      if (!m_busy && st) begin
        m_busy <= 1; m_dir <= stx;
        if (stx) begin m_rx <= 0; m_tx <= (m_tx > 8) ? 8 : m_tx; end
        else begin m_tx <= 0; m_rx <= (m_rx > 8) ? 8 : m_rx; end
      end else if (m_busy) begin
        if (er) m_busy <= 0;
        else if (bd) begin
          if (fin) m_busy <= 0;
          else if (m_dir) m_rx <= m_rx + 1;
          else m_tx <= m_tx + 1;
        end
      end else if (wr) begin
        m_rx <= wrx; m_tx <= wtx;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (run_cmp) begin
    chk(int'(rx_o) == m_rx, "R6 model rx field", rx_o, m_rx);
    chk(int'(tx_o) == m_tx, "R6 model tx field", tx_o, m_tx);
    chk(busy_o == m_busy, "R3 model busy", busy_o, m_busy);
    chk(chk_o == (m_busy && m_rx == m_tx), "R7 model chk_next", chk_o, m_busy && m_rx == m_tx);
    chk(done_o == m_done, "R8 model done", done_o, m_done);
  end

  task automatic cyc(input bit w, input int a, input int b, input bit s, input bit d,
                     input bit bdone, input bit e);
    wr = w; wrx = 4'(a); wtx = 4'(b); st = s; stx = d; bd = bdone; er = e;
    @(negedge clk);
    wr = 0; st = 0; bd = 0; er = 0;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rx_o == 0 && tx_o == 0, "R1 reset fields", {rx_o, tx_o}, 0);
    chk(!busy_o && !chk_o && !done_o, "R1 reset flags", {busy_o, chk_o, done_o}, 0);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);

    cyc(1, 12, 5, 0, 0, 0, 0);
    chk(rx_o == 12 && tx_o == 5, "R2 idle write", {rx_o, tx_o}, {4'd12, 4'd5});
    cyc(1, 1, 1, 1, 1, 0, 0);
    chk(busy_o && tx_o == 5 && rx_o == 0, "R10 R3 tx start with write", {busy_o, tx_o, rx_o}, {1'b1, 4'd5, 4'd0});
    for (int i = 0; i < 5; i++) begin
      chk(!chk_o, "R7 no chk before count", chk_o, 0);
      cyc(0, 0, 0, 0, 0, 1, 0);
    end
    chk(rx_o == 5 && chk_o, "R6 tx count reached", {rx_o, chk_o}, {4'd5, 1'b1});
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(done_o && !busy_o && rx_o == 5 && tx_o == 5, "R8 checksum done", {done_o, busy_o}, 2'b10);
    @(negedge clk);
    chk(!done_o, "R8 one cycle pulse", done_o, 0);

    cyc(1, 15, 3, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk(rx_o == 8 && tx_o == 0, "R3 rx clamp", {rx_o, tx_o}, {4'd8, 4'd0});
    cyc(1, 2, 2, 0, 0, 0, 0);
    chk(rx_o == 8 && tx_o == 0, "R10 write while busy", {rx_o, tx_o}, {4'd8, 4'd0});
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk(rx_o == 8 && tx_o == 0 && busy_o, "R10 start while busy", {rx_o, tx_o}, {4'd8, 4'd0});
    repeat (3) cyc(0, 0, 0, 0, 0, 1, 0);
    chk(tx_o == 3, "R6 rx count", tx_o, 3);
    cyc(0, 0, 0, 0, 0, 1, 1);
    chk(!busy_o && !done_o && tx_o == 3 && rx_o == 8, "R9 error with byte", {busy_o, done_o, tx_o}, {1'b0, 1'b0, 4'd3});

    cyc(0, 0, 0, 0, 0, 1, 1);
    chk(!busy_o && tx_o == 3 && rx_o == 8, "R11 idle strobes", {rx_o, tx_o}, {4'd8, 4'd3});

    cyc(1, 9, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 0, 0);
    chk(chk_o && busy_o, "R4 tx zero length", chk_o, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk(done_o && !busy_o, "R4 checksum only", done_o, 1);

    cyc(1, 0, 7, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk(chk_o && busy_o, "R5 rx zero length", chk_o, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk(!busy_o && !done_o, "R9 abort at checksum", {busy_o, done_o}, 0);

    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 8, $urandom_range(0, 15), $urandom_range(0, 15), r >= 8 && r < 16,
          $urandom_range(0, 1), $urandom_range(0, 99) < 55, $urandom_range(0, 99) < 4);
    end

    run_cmp = 0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule